// File: doc/BRIEF.md
# NAND Command Word Loader

This block is the command register bank of a NAND flash controller. Software does not address each command word separately. It writes every 32-bit word of a command to one port address, the first buffer's address. An internal pointer steers each accepted write into the next buffer: buffer 0, then 1, then 2, and, in long mode, buffer 3. Each buffer can still be read at its own address. Writes to the addresses of buffers 1 to 3 are discarded.

A command is three words long by default. When the parameter `HAS_BUF3` is set, a mode bit in the control register makes commands four words long. The extra word carries a transfer length count, which allows non-standard transfers such as reading a parameter page. The mode is latched when the first word of a command is accepted.

When the final word lands, the block raises a one-cycle ready strobe and returns the pointer to buffer 0. It then holds the command pending until the downstream sequencer pulses `cmd_done`. A command word written while a command is pending is dropped, and a sticky overrun flag is set. Setting the abort bit clears the pointer, all buffers, the pending state and the overrun flag.

Top module: `cmd_loader`

## Requirements
- R1: After synchronous reset, every readable address returns zero and `cmd_ready`, `cmd_pending` and `len_valid` are low.
- R2: Successive accepted writes to address 0 land in buffer 0, buffer 1, buffer 2 and, in a long command, buffer 3, strictly in that order.
- R3: `cmd_ready` is high for exactly one cycle, namely the cycle after the edge that captured the final word (word 3 of a short command, word 4 of a long one). It stays low after earlier words, and `cmd_pending` rises together with it.
- R4: Writes to addresses 1, 2, 3 and 5 to 7 change no buffer and do not move the pointer.
- R5: Buffer n reads back at address n (n = 0..3). Address 4 reads the status word: bit 0 pending, bit 1 long mode, bit 2 overrun, other bits zero. Addresses 5 to 7 read zero.
- R6: With `HAS_BUF3`=1, writing address 4 with bit 1 set selects four-word commands. The fourth word is stored in buffer 3, and the command completes only after it.
- R7: While a long command is pending, `len_valid` is 1 and `len_count` equals bits 15:0 of buffer 3. Otherwise both outputs are 0.
- R8: A write to address 0 while a command is pending is dropped and leaves all buffers unchanged. It also sets the overrun flag (status bit 2), which stays set until abort or reset.
- R9: A `cmd_done` pulse clears pending. The next write to address 0 then goes into buffer 0.
- R10: Writing address 4 with bit 0 set (abort) clears the pointer, all buffers, pending and overrun in the same edge. The next command then starts at buffer 0.
- R11: The command length is fixed by the mode bit in effect when word 0 is accepted. Changing the mode mid-command does not change how many words that command takes.
- R12: A reset asserted in the middle of a command discards the partial words, and the next command starts at buffer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| cmd_done | input | 1 | Sequencer has consumed the pending command |
| cmd_ready | output | 1 | One-cycle strobe: a complete command was captured |
| cmd_pending | output | 1 | A captured command awaits cmd_done |
| len_valid | output | 1 | Pending command is a long command |
| len_count | output | LEN_W | Transfer length from buffer 3 |

## Verification
A sweep of commands alternates short and long mode. Each word carries a value derived arithmetically from its command and word index, so any misrouted or swapped word shows up at readback. Stray writes are injected in the middle of a command to the read-only buffer addresses and to the unused addresses. This separates a pointer that advances on any write from one that advances only on the port address. Further sequences cover these cases:
- a write while a command is pending;
- an abort after two words;
- a mode change between word 0 and word 1, in both directions;
- a reset in the middle of a command.

Together they separate a sticky overrun flag from one that clears, and a latched length from one that follows the live mode bit.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 3;
    localparam int SLOT_W = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [SLOT_W-1:0] {
        SLOT0 = 2'd0,
        SLOT1 = 2'd1,
        SLOT2 = 2'd2,
        SLOT3 = 2'd3
    } slot_e;

    // register map (word addresses)
    localparam addr_t A_PORT = 3'd0;
    localparam addr_t A_CTRL = 3'd4;

    // control / status bit positions
    localparam int B_ABORT   = 0;
    localparam int B_PENDING = 0;
    localparam int B_LONG    = 1;
    localparam int B_OVERRUN = 2;

    typedef struct packed {
        logic pending;
        logic long_mode;
        logic overrun;
    } status_t;

    function automatic slot_e final_slot(input logic long_cmd);
        return long_cmd ? SLOT3 : SLOT2;
    endfunction

    function automatic word_t pack_status(input status_t s);
        word_t w;
        w            = '0;
        w[B_PENDING] = s.pending;
        w[B_LONG]    = s.long_mode;
        w[B_OVERRUN] = s.overrun;
        return w;
    endfunction

endpackage

// File: rtl/cmdl_steer.sv
module cmdl_steer
    import cmdl_pkg::*;
#(
    parameter bit HAS_BUF3 = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  abort,
    input  logic  ld_req,
    input  logic  mode_long,
    input  logic  done,
    output logic  ld_accept,
    output slot_e ld_slot,
    output logic  cmd_ready,
    output logic  pending,
    output logic  overrun,
    output logic  cmd_long
);

    slot_e slot_q;
    logic  long_q;
    logic  ready_q;
    logic  pend_q;
    logic  ovr_q;
    logic  eff_long;

    assign ld_accept = ld_req && !pend_q;
    assign eff_long  = (slot_q == SLOT0) ? (mode_long && HAS_BUF3) : long_q;
    assign ld_slot   = slot_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            slot_q  <= SLOT0;
            long_q  <= 1'b0;
            ready_q <= 1'b0;
            pend_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            ready_q <= 1'b0;
            if (ld_accept) begin
                if (slot_q == SLOT0) begin
                    long_q <= mode_long && HAS_BUF3;
                end
                if (slot_q == final_slot(eff_long)) begin
                    slot_q  <= SLOT0;
                    ready_q <= 1'b1;
                    pend_q  <= 1'b1;
                end else begin
                    slot_q <= slot_e'(slot_q + 2'd1);
                end
            end
            if (ld_req && pend_q) begin
                ovr_q <= 1'b1;
            end
            if (done && pend_q) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign cmd_ready = ready_q;
    assign pending   = pend_q;
    assign overrun   = ovr_q;
    assign cmd_long  = long_q;

    assert_ready_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        ready_q |=> !ready_q);

    assert_ready_with_pending_R3: assert property (@(posedge clk) disable iff (rst)
        ready_q |-> pend_q);

    assert_drop_keeps_slot_R8: assert property (@(posedge clk) disable iff (rst)
        (ld_req && pend_q && !abort) |=> ($stable(slot_q) && ovr_q));

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !abort) |=> ovr_q);

    assert_slot3_only_long_R6: assert property (@(posedge clk) disable iff (rst)
        (slot_q == SLOT3) |-> long_q);

    assert_abort_clears_R10: assert property (@(posedge clk) disable iff (rst)
        abort |=> (slot_q == SLOT0 && !pend_q && !ovr_q));

endmodule

// File: rtl/cmdl_store.sv
module cmdl_store
    import cmdl_pkg::*;
#(
    parameter int NUM_BUF = 4
) (
    input  logic                     clk,
    input  logic                     clear,
    input  logic                     we,
    input  slot_e                    slot,
    input  word_t                    data,
    output logic [NUM_BUF-1:0][WORD_W-1:0] bufs
);

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        always_ff @(posedge clk) begin
            if (clear) begin
                bufs[g] <= '0;
            end else if (we && (slot == slot_e'(g))) begin
                bufs[g] <= data;
            end
        end
    end

endmodule

// File: rtl/cmdl_readmux.sv
module cmdl_readmux
    import cmdl_pkg::*;
#(
    parameter int NUM_BUF = 4
) (
    input  addr_t                          rd_addr,
    input  logic [NUM_BUF-1:0][WORD_W-1:0] bufs,
    input  status_t                        status,
    output word_t                          rd_data
);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (rd_addr == addr_t'(i)) begin
                rd_data = bufs[i];
            end
        end
        if (rd_addr == A_CTRL) begin
            rd_data = pack_status(status);
        end
    end

endmodule

// File: rtl/cmd_loader.sv
module cmd_loader
    import cmdl_pkg::*;
#(
    parameter bit HAS_BUF3 = 1'b1,
    parameter int LEN_W    = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [WORD_W-1:0]     rd_data,
    input  logic                  cmd_done,
    output logic                  cmd_ready,
    output logic                  cmd_pending,
    output logic                  len_valid,
    output logic [LEN_W-1:0]      len_count
);

    localparam int NUM_BUF = HAS_BUF3 ? 4 : 3;

    logic    ctrl_wr;
    logic    abort;
    logic    port_wr;
    logic    mode_q;
    logic    ld_accept;
    slot_e   ld_slot;
    logic    pend;
    logic    ovr;
    logic    long_cmd;
    status_t status;
    logic [NUM_BUF-1:0][WORD_W-1:0] bufs;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign abort   = ctrl_wr && wr_data[B_ABORT];
    assign port_wr = wr_en && (wr_addr == A_PORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q <= wr_data[B_LONG] && HAS_BUF3;
        end
    end

    cmdl_steer #(.HAS_BUF3(HAS_BUF3)) u_steer (
        .clk       (clk),
        .rst       (rst),
        .abort     (abort),
        .ld_req    (port_wr),
        .mode_long (mode_q),
        .done      (cmd_done),
        .ld_accept (ld_accept),
        .ld_slot   (ld_slot),
        .cmd_ready (cmd_ready),
        .pending   (pend),
        .overrun   (ovr),
        .cmd_long  (long_cmd)
    );

    cmdl_store #(.NUM_BUF(NUM_BUF)) u_store (
        .clk   (clk),
        .clear (rst || abort),
        .we    (ld_accept),
        .slot  (ld_slot),
        .data  (wr_data),
        .bufs  (bufs)
    );

    assign status = '{pending: pend, long_mode: mode_q, overrun: ovr};

    cmdl_readmux #(.NUM_BUF(NUM_BUF)) u_rd (
        .rd_addr (rd_addr),
        .bufs    (bufs),
        .status  (status),
        .rd_data (rd_data)
    );

    assign cmd_pending = pend;

    if (HAS_BUF3) begin : g_len
        assign len_valid = pend && long_cmd;
        assign len_count = len_valid ? bufs[3][LEN_W-1:0] : '0;
    end else begin : g_nolen
        logic unused_long;
        assign unused_long = long_cmd;
        assign len_valid   = 1'b0;
        assign len_count   = '0;
    end

    assert_side_writes_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != A_PORT && wr_addr != A_CTRL) |=> $stable(bufs));

    assert_len_zero_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !cmd_pending |-> (len_count == '0 && !len_valid));

    assert_pending_until_done_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_pending && !cmd_done && !abort) |=> cmd_pending);

endmodule

// File: tb/tb_cmd_loader.sv
`timescale 1ns/1ps
module tb_cmd_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        cmd_done = 1'b0;
    logic        cmd_ready;
    logic        cmd_pending;
    logic        len_valid;
    logic [15:0] len_count;

    int nchecks = 0;
    int nfails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cmd_loader dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cmd_done(cmd_done),
        .cmd_ready(cmd_ready), .cmd_pending(cmd_pending),
        .len_valid(len_valid), .len_count(len_count)
    );

    function automatic logic [31:0] pat(input int i, input int k);
        return (32'h9E37_79B9 * (i + 1)) ^ (32'h1111_1111 * k) ^ 32'(k + 7 * i);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // write one register; rdy returns cmd_ready in the cycle after the edge
    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d, output logic rdy);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        rdy = cmd_ready;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    function automatic logic [31:0] st(input bit pend, input bit lng, input bit ovr);
        return {29'b0, ovr, lng, pend};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchecks++;
            nfails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
            $finish;
        end
    end

    initial begin : main
        logic        r;
        logic [31:0] d;
        bit          ovr_exp;
        ovr_exp = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            bus_rd(3'(a), d);
            chk("R1 reset readback", d, 32'h0);
        end
        chk("R1 reset ready", {31'b0, cmd_ready}, 32'h0);
        chk("R1 reset pending", {31'b0, cmd_pending}, 32'h0);
        chk("R1 reset len_valid", {31'b0, len_valid}, 32'h0);

        // sweep of commands, alternating short and long
        for (int i = 0; i < 12; i++) begin
            bit lng;
            int n;
            lng = i[0];
            n = lng ? 4 : 3;
            bus_wr(3'd4, {30'b0, lng, 1'b0}, r);
            for (int k = 0; k < n; k++) begin
                bus_wr(3'd0, pat(i, k), r);
                chk((k == n - 1) ? "R3 ready after final word" : "R3 no ready early",
                    {31'b0, r}, {31'b0, (k == n - 1)});
                if (i == 2 && k == 0) begin
                    // R4: stray writes to read-only and unused addresses
                    bus_wr(3'd1, 32'hDEAD_0001, r);
                    bus_wr(3'd2, 32'hDEAD_0002, r);
                    bus_wr(3'd3, 32'hDEAD_0003, r);
                    bus_wr(3'd5, 32'hDEAD_0005, r);
                    bus_wr(3'd7, 32'hDEAD_0007, r);
                    bus_rd(3'd1, d);
                    chk("R4 buffer1 untouched", d, (i > 0) ? pat(1, 1) : 32'h0);
                end
            end
            @(negedge clk);
            chk("R3 ready one cycle", {31'b0, cmd_ready}, 32'h0);
            chk("R3 pending held", {31'b0, cmd_pending}, 32'h1);
            for (int k = 0; k < n; k++) begin
                bus_rd(3'(k), d);
                chk((k == 3) ? "R6 buffer3 word" : "R2 R5 ordered readback", d, pat(i, k));
            end
            bus_rd(3'd4, d);
            chk("R5 status word", d, st(1'b1, lng, ovr_exp));
            chk("R7 len_valid", {31'b0, len_valid}, {31'b0, lng});
            chk("R7 len_count", {16'b0, len_count}, lng ? {16'b0, pat(i, 3)[15:0]} : 32'h0);

            if (i == 5) begin
                // R8: write while pending is dropped
                bus_wr(3'd0, 32'hBAD0_BAD0, r);
                chk("R8 no ready on dropped", {31'b0, r}, 32'h0);
                ovr_exp = 1'b1;
                for (int k = 0; k < 4; k++) begin
                    bus_rd(3'(k), d);
                    chk("R8 buffers unchanged", d, pat(i, k));
                end
                bus_rd(3'd4, d);
                chk("R8 overrun set", d, st(1'b1, 1'b1, 1'b1));
            end
            pulse_done();
            chk("R9 pending cleared", {31'b0, cmd_pending}, 32'h0);
            chk("R7 len_valid idle", {31'b0, len_valid}, 32'h0);
        end
        bus_rd(3'd4, d);
        chk("R8 overrun sticky", d, st(1'b0, 1'b1, 1'b1));

        // R9: after done, first word goes to buffer 0
        bus_wr(3'd4, 32'h0, r);
        bus_wr(3'd0, 32'h0000_AAAA, r);
        bus_rd(3'd0, d);
        chk("R9 next word in buffer0", d, 32'h0000_AAAA);
        bus_wr(3'd0, 32'h0000_BBBB, r);

        // R10: abort mid-command
        bus_wr(3'd4, 32'h1, r);
        for (int a = 0; a < 4; a++) begin
            bus_rd(3'(a), d);
            chk("R10 buffers cleared", d, 32'h0);
        end
        bus_rd(3'd4, d);
        chk("R10 status cleared", d, st(1'b0, 1'b0, 1'b0));
        bus_wr(3'd0, 32'h0000_0C01, r);
        bus_wr(3'd0, 32'h0000_0C02, r);
        chk("R10 no early ready", {31'b0, r}, 32'h0);
        bus_wr(3'd0, 32'h0000_0C03, r);
        chk("R10 ready on third", {31'b0, r}, 32'h1);
        bus_rd(3'd0, d);
        chk("R10 restart at buffer0", d, 32'h0000_0C01);
        pulse_done();

        // R11: short mode latched, switched to long mid-command
        bus_wr(3'd0, 32'h0000_1101, r);
        bus_wr(3'd4, 32'h2, r);
        bus_wr(3'd0, 32'h0000_1102, r);
        bus_wr(3'd0, 32'h0000_1103, r);
        chk("R11 short kept", {31'b0, r}, 32'h1);
        chk("R11 short no len", {31'b0, len_valid}, 32'h0);
        pulse_done();
        // R11: long mode latched, switched to short mid-command
        bus_wr(3'd0, 32'h0000_2201, r);
        bus_wr(3'd4, 32'h0, r);
        bus_wr(3'd0, 32'h0000_2202, r);
        bus_wr(3'd0, 32'h0000_2203, r);
        chk("R11 long not done at three", {31'b0, r}, 32'h0);
        bus_wr(3'd0, 32'h0001_2204, r);
        chk("R11 long done at four", {31'b0, r}, 32'h1);
        chk("R11 R7 len_count", {16'b0, len_count}, 32'h0000_2204);
        pulse_done();

        // R12: reset mid-command
        bus_wr(3'd0, 32'h0000_3301, r);
        bus_wr(3'd0, 32'h0000_3302, r);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 5; a++) begin
            bus_rd(3'(a), d);
            chk("R12 cleared by reset", d, 32'h0);
        end
        bus_wr(3'd0, 32'h0000_4401, r);
        bus_wr(3'd0, 32'h0000_4402, r);
        bus_wr(3'd0, 32'h0000_4403, r);
        chk("R12 ready on third", {31'b0, r}, 32'h1);
        bus_rd(3'd0, d);
        chk("R12 restart at buffer0", d, 32'h0000_4401);
        bus_rd(3'd2, d);
        chk("R12 buffer2", d, 32'h0000_4403);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
        $finish;
    end

endmodule